// File: doc/BRIEF.md
# RTC Prescaler and BCD Seconds Counter

This block turns a 32.768 kHz reference clock into timekeeping at one-second resolution. A prescaler counts `DIV` reference cycles and gives one tick per second. The tick advances a seconds value held as two BCD digits. When the value rolls from 59 to 00, the block sends a single-cycle carry to a minutes stage, which sits outside this block.

The seconds byte carries a clock-integrity flag in its top bit. The flag comes up set at power-on. A brown-out input sets it again, and only a host write that puts 0 in that bit clears it. A host write to the seconds byte also clears the prescaler, so the second that follows the write is a full second long.

A stop input freezes timekeeping. While stop is high, every prescaler flip-flop is held at zero asynchronously. The raw reference clock is still passed to the clock-out pin through its own enable gate.

Top module: `rtc_sec_core`

## Requirements
- R1: While `rst_i` is high, a clock edge sets `sec_o` to 8'h80 and `min_carry_o` to 0. That value means the integrity flag is set and the seconds are 00.
- R2: With stop low and no writes, the seconds value advances by exactly one every `DIV` clock cycles.
- R3: The units digit is `sec_o[3:0]` and the tens digit is `sec_o[6:4]`. Units count from 0 to 9. When units go from 9 to 0, the tens digit increments in the same edge.
- R4: When the seconds advance from 59, they become 00. In that same edge, `min_carry_o` goes high for exactly one cycle. It is 0 at every other time.
- R5: A clock edge with `sec_wr_i` high loads `sec_wdata_i` into `sec_o`. Bit 7 is the integrity flag, bits 6:4 are tens and bits 3:0 are units. A write takes priority over a tick in the same edge and produces no carry.
- R6: A write clears the prescaler. The first advance after a write edge comes `DIV`+1 edges later.
- R7: While `stop_i` is high, the seconds value holds and no carry occurs. A stop pulse of any length clears the prescaler at once. After stop falls, the first advance comes `DIV`+1 edges later.
- R8: While the registered enable is 1, `clkout_o` follows `clk_i`, and `stop_i` has no effect on it. While the enable is 0, `clkout_o` is 0. The enable is sampled from `clkout_en_i` on the falling clock edge.
- R9: The integrity flag (`sec_o[7]`) stays set while the seconds advance. `brownout_i` high at an edge sets the flag, and this wins over a write in the same edge. Only a write with bit 7 equal to 0 clears the flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | 32.768 kHz reference clock |
| rst_i | input | 1 | Power-on reset, synchronous, active high |
| stop_i | input | 1 | Stop control; high freezes timekeeping and clears the prescaler asynchronously |
| brownout_i | input | 1 | Brown-out indication; sets the integrity flag |
| sec_wr_i | input | 1 | Host write strobe for the seconds byte |
| sec_wdata_i | input | 8 | Host write data: flag, tens, units |
| clkout_en_i | input | 1 | Clock-out enable request |
| sec_o | output | 8 | Seconds byte: {flag, tens[2:0], units[3:0]} |
| min_carry_o | output | 1 | One-cycle carry to the minutes counter on 59 to 00 |
| clkout_o | output | 1 | Gated copy of the reference clock |

## Verification
On every cycle, the assertions check the following:
- the carry appears only on a 59-to-00 step and never lasts two cycles;
- a write loads the byte unless brown-out overrides the flag;
- the units digit moves only by one or to zero;
- the seconds hold whenever stop was sampled high;
- the integrity flag never clears without a write.

Some behaviour depends on how many cycles pass, so only the bench scenarios can show it. These are the period of `DIV` cycles between advances and the full second after a write or a stop release. The bench uses a short stop pulse that lies between clock edges to show that the prescaler is cleared asynchronously. Its scenarios also cover the clock-out waveform while stopped and while disabled.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int SEC_W     = 8;
  localparam int UNITS_W   = 4;
  localparam int TENS_W    = 3;
  localparam int UNITS_MAX = 9;
  localparam int TENS_MAX  = 5;
  localparam int FLAG_BIT  = 7;
  localparam logic [SEC_W-1:0] SEC_RESET = 8'h80;
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int DIV = 32768
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic stop_i,
  input  logic clr_i,
  output logic tick_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  // stop clears the whole chain without waiting for a clock edge
  always_ff @(posedge clk_i or posedge stop_i) begin
    if (stop_i) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else if (rst_i || clr_i) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else if (cnt_q == LAST) begin
      cnt_q  <= '0;
      tick_o <= 1'b1;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
      tick_o <= 1'b0;
    end
  end
endmodule

// File: rtl/rtc_bcd_digit.sv
module rtc_bcd_digit #(
  parameter int W   = 4,
  parameter int MAX = 9
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         inc_i,
  output logic [W-1:0] q_o,
  output logic         at_max_o
);
  localparam logic [W-1:0] TOP = W'(MAX);

  assign at_max_o = (q_o >= TOP);

  always_ff @(posedge clk_i) begin
    if (rst_i)       q_o <= '0;
    else if (load_i) q_o <= load_val_i;
    else if (inc_i)  q_o <= at_max_o ? '0 : q_o + 1'b1;
  end
endmodule

// File: rtl/rtc_clkout_gate.sv
module rtc_clkout_gate (
  input  logic clk_i,
  input  logic rst_i,
  input  logic en_i,
  output logic clk_o
);
  logic en_q;

  // enable changes only while the clock is low, so the gated output has no runt pulses
  always_ff @(negedge clk_i) begin
    if (rst_i) en_q <= 1'b0;
    else       en_q <= en_i;
  end

  assign clk_o = clk_i & en_q;
endmodule

// File: rtl/rtc_sec_core.sv
module rtc_sec_core
  import rtc_pkg::*;
#(
  parameter int DIV = 32768
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             stop_i,
  input  logic             brownout_i,
  input  logic             sec_wr_i,
  input  logic [SEC_W-1:0] sec_wdata_i,
  input  logic             clkout_en_i,
  output logic [SEC_W-1:0] sec_o,
  output logic             min_carry_o,
  output logic             clkout_o
);
  logic               tick;
  logic [UNITS_W-1:0] units_q;
  logic [TENS_W-1:0]  tens_q;
  logic               units_top, tens_top;
  logic               flag_q, carry_q;
  logic               adv;

  assign adv = tick & ~sec_wr_i;

  rtc_prescaler #(.DIV(DIV)) u_pre (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .stop_i(stop_i),
    .clr_i (sec_wr_i),
    .tick_o(tick)
  );

  rtc_bcd_digit #(.W(UNITS_W), .MAX(UNITS_MAX)) u_units (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .load_i    (sec_wr_i),
    .load_val_i(sec_wdata_i[UNITS_W-1:0]),
    .inc_i     (adv),
    .q_o       (units_q),
    .at_max_o  (units_top)
  );

  rtc_bcd_digit #(.W(TENS_W), .MAX(TENS_MAX)) u_tens (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .load_i    (sec_wr_i),
    .load_val_i(sec_wdata_i[UNITS_W +: TENS_W]),
    .inc_i     (adv & units_top),
    .q_o       (tens_q),
    .at_max_o  (tens_top)
  );

  rtc_clkout_gate u_cko (
    .clk_i(clk_i),
    .rst_i(rst_i),
    .en_i (clkout_en_i),
    .clk_o(clkout_o)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      flag_q  <= SEC_RESET[FLAG_BIT];
      carry_q <= 1'b0;
    end else begin
      if (brownout_i)    flag_q <= 1'b1;
      else if (sec_wr_i) flag_q <= sec_wdata_i[FLAG_BIT];
      carry_q <= adv & units_top & tens_top;
    end
  end

  assign sec_o       = {flag_q, tens_q, units_q};
  assign min_carry_o = carry_q;
endmodule

// File: rtl/rtc_sec_core_chk.sv
module rtc_sec_core_chk (
  input logic       clk_i,
  input logic       rst_i,
  input logic       stop_i,
  input logic       brownout_i,
  input logic       sec_wr_i,
  input logic [7:0] sec_wdata_i,
  input logic [7:0] sec_o,
  input logic       min_carry_o
);
  assert_carry_at_rollover_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    min_carry_o |-> (sec_o[6:0] == 7'h00) && ($past(sec_o[6:0]) == 7'h59));

  assert_carry_single_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    min_carry_o |=> !min_carry_o);

  assert_write_loads_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    ($past(sec_wr_i) && !$past(brownout_i) && !$past(rst_i)) |-> (sec_o == $past(sec_wdata_i)));

  assert_units_step_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    (!$past(sec_wr_i) && (sec_o[3:0] != $past(sec_o[3:0])))
      |-> ((sec_o[3:0] == 4'd0) || (sec_o[3:0] == $past(sec_o[3:0]) + 4'd1)));

  assert_stop_holds_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    ($past(stop_i) && !$past(sec_wr_i) && !$past(rst_i)) |-> ($stable(sec_o[6:0]) && !min_carry_o));

  assert_flag_sticky_R9: assert property (@(posedge clk_i) disable iff (rst_i)
    ($past(sec_o[7]) && !$past(sec_wr_i)) |-> sec_o[7]);

  assert_brownout_sets_R9: assert property (@(posedge clk_i) disable iff (rst_i)
    $past(brownout_i) |-> sec_o[7]);
endmodule

bind rtc_sec_core rtc_sec_core_chk u_chk (
  .clk_i      (clk_i),
  .rst_i      (rst_i),
  .stop_i     (stop_i),
  .brownout_i (brownout_i),
  .sec_wr_i   (sec_wr_i),
  .sec_wdata_i(sec_wdata_i),
  .sec_o      (sec_o),
  .min_carry_o(min_carry_o)
);

// File: tb/rtc_sec_core_test.sv
module rtc_sec_core_test;
  localparam int DIV = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       stop = 1'b0, brownout = 1'b0, wr = 1'b0, cko_en = 1'b1;
  logic [7:0] wdata = 8'h00;
  logic [7:0] sec;
  logic       carry, cko;

  int total = 0;
  int bad   = 0;

  typedef struct {
    logic [7:0] sec;
    logic       carry;
    string      tag;
  } exp_t;
  exp_t q[$];

  always #4 clk = ~clk;

  rtc_sec_core #(.DIV(DIV)) uut (
    .clk_i(clk), .rst_i(rst), .stop_i(stop), .brownout_i(brownout),
    .sec_wr_i(wr), .sec_wdata_i(wdata), .clkout_en_i(cko_en),
    .sec_o(sec), .min_carry_o(carry), .clkout_o(cko)
  );

  // monitor: compares the state after the latest edge against queued expectations
  always @(negedge clk) begin
    while (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      total++;
      if (sec !== e.sec || carry !== e.carry) begin
        bad++;
        $display("FAIL %s: sec=%h carry=%b expected sec=%h carry=%b",
                 e.tag, sec, carry, e.sec, e.carry);
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic expect_st(input logic [7:0] s, input logic c, input string tag);
    exp_t e;
    e.sec = s; e.carry = c; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic chk_bit(input logic act, input logic exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic write_sec(input logic [7:0] v);
    wr = 1'b1; wdata = v;
    step(1);
    wr = 1'b0;
  endtask

  initial begin
    #(8 * 50000);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    step(3);
    rst = 1'b0;
    expect_st(8'h80, 1'b0, "R1 reset value");

    // full second after write, then steady period
    write_sec(8'h05);
    expect_st(8'h05, 1'b0, "R5 load value");
    step(DIV);     expect_st(8'h05, 1'b0, "R6 no advance before full second");
    step(1);       expect_st(8'h06, 1'b0, "R6 first advance after write");
    step(DIV - 1); expect_st(8'h06, 1'b0, "R2 holds within period");
    step(1);       expect_st(8'h07, 1'b0, "R2 advance after DIV cycles");

    // units roll into tens
    write_sec(8'h09); step(DIV + 1); expect_st(8'h10, 1'b0, "R3 09 to 10");
    write_sec(8'h39); step(DIV + 1); expect_st(8'h40, 1'b0, "R3 39 to 40");

    // minute rollover
    write_sec(8'h59);
    step(DIV); expect_st(8'h59, 1'b0, "R4 before rollover");
    step(1);   expect_st(8'h00, 1'b1, "R4 rollover with carry");
    step(1);   expect_st(8'h00, 1'b0, "R4 carry one cycle only");

    // stop holds and clock-out keeps running
    write_sec(8'h20);
    step(3);
    stop = 1'b1;
    step(3 * DIV); expect_st(8'h20, 1'b0, "R7 held while stopped");
    chk_bit(cko, 1'b1, "R8 clkout high phase during stop");
    #4;
    chk_bit(cko, 1'b0, "R8 clkout low phase during stop");
    step(1);
    stop = 1'b0;
    step(DIV); expect_st(8'h20, 1'b0, "R7 full second after release");
    step(1);   expect_st(8'h21, 1'b0, "R7 first advance after release");

    // short stop pulse between edges clears the prescaler
    write_sec(8'h30);
    step(DIV - 2);
    stop = 1'b1; #2; stop = 1'b0;
    step(DIV); expect_st(8'h30, 1'b0, "R7 pulse cleared prescaler");
    step(1);   expect_st(8'h31, 1'b0, "R7 advance after pulse");

    // integrity flag
    brownout = 1'b1; step(1); brownout = 1'b0;
    expect_st(8'hB1, 1'b0, "R9 brownout sets flag");
    step(DIV - 2); expect_st(8'hB1, 1'b0, "R9 flag held");
    step(1);       expect_st(8'hB2, 1'b0, "R9 flag kept across advance");
    wr = 1'b1; wdata = 8'h15; brownout = 1'b1;
    step(1);
    wr = 1'b0; brownout = 1'b0;
    expect_st(8'h95, 1'b0, "R9 brownout wins over write");
    write_sec(8'hC2); expect_st(8'hC2, 1'b0, "R5 write with flag set");
    write_sec(8'h42); expect_st(8'h42, 1'b0, "R9 write zero clears flag");

    // clock-out disable
    cko_en = 1'b0;
    step(1);
    chk_bit(cko, 1'b0, "R8 clkout gated off");
    cko_en = 1'b1;
    step(1);
    chk_bit(cko, 1'b1, "R8 clkout enabled again");

    step(2);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule